// File: doc/BRIEF.md
# Mode-Dependent GPIO Port with Pin Muxing

An eight-pin general-purpose I/O port for a microcontroller. Software sees two byte registers on a simple register bus. One is a write-only direction register and the other is a data register. Each pin then works out its final output enable and output value from three things: its direction bit, the operating mode strap, and a few alternate-function overrides. The pad interface has one output-enable vector and one output-value vector. The pad inputs pass through a synchroniser before they are read.

The pins have fixed roles:

- Three pins always carry the external bus strobes (address strobe, high write strobe, read strobe), whatever their direction bits say.
- One pin turns into the system clock output when its direction bit is set. Otherwise it is an input that also feeds a subclock consumer.
- One pin becomes the bus wait input when the wait function is enabled.
- The remaining pins are plain port pins.

Hardware standby reloads the registers with their reset values. Software standby freezes them. The `rst_n` input is expected to be already released synchronously to `clk`. The `mode` strap must be stable while reset is asserted.

Top module: `gpio_mux_port`

## Requirements
- R1: A write lands on the rising edge where `reg_wr` is high and `reg_addr` matches. The direction register is at 0xFFC0 and the data register is at 0xFFC1. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: After reset the direction register holds 0x40 when `mode` is 1 and 0x00 for any other mode, and the data register holds 0x00. The reset direction value is observable on `pad_oe`.
- R3: Each clock edge with `hw_stby` high reloads both registers with their R2 reset values.
- R4: While `sw_stby` is high and `hw_stby` is low, both registers keep their contents and register writes are ignored.
- R5: Pins 5, 4 and 3 are always enabled. They drive `as_n`, `hwr_n` and `rd_n` respectively, regardless of direction or data bits.
- R6: While `wait_en` is high, pin 7 is an input (`pad_oe[7]` low).
- R7: Pin 6 is enabled and drives `sys_clk` when direction bit 6 is 1. When the bit is 0, pin 6 is an input and `pad_out[6]` carries data bit 6.
- R8: Pins 2, 1, 0, and pin 7 when `wait_en` is low, take their output enable from their direction bit and their output value from their data bit.
- R9: A read of 0xFFC1 returns the data bit where the direction bit is 1 and the synchronised pad level where it is 0. A pad change becomes visible after exactly two rising edges.
- R10: `wait_out` and `subclk_out` present the synchronised levels of pads 7 and 6, with the same two-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| mode | input | 2 | Operating mode strap (1, 2 or 3) |
| hw_stby | input | 1 | Hardware standby: reload reset values |
| sw_stby | input | 1 | Software standby: freeze registers |
| wait_en | input | 1 | Pin 7 serves as the bus wait input |
| reg_addr | input | 16 | Register bus address (lower 16 bits) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| sys_clk | input | 1 | System clock level routed to pin 6 |
| as_n | input | 1 | Address strobe from the bus controller |
| hwr_n | input | 1 | High write strobe from the bus controller |
| rd_n | input | 1 | Read strobe from the bus controller |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| wait_out | output | 1 | Synchronised pin 7 level for the wait controller |
| subclk_out | output | 1 | Synchronised pin 6 level for the subclock consumer |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and the register addresses 0xFFC0 and 0xFFC1. With two stages, the one-edge intermediate state of the read path can be observed as well as the settled value. This makes the latency check in R9 exact and not just eventual. The mode strap is an input, not a parameter. One build therefore reaches both reset values, through a mode-1 reset, a mode-1 hardware standby and a mode-2 reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W   = 8;
  localparam int PIN_WAIT = 7;
  localparam int PIN_CLK  = 6;
  localparam int PIN_AS   = 5;
  localparam int PIN_HWR  = 4;
  localparam int PIN_RD   = 3;

  typedef enum logic [1:0] {
    ROLE_PLAIN  = 2'd0,
    ROLE_WAIT   = 2'd1,
    ROLE_CLK    = 2'd2,
    ROLE_STROBE = 2'd3
  } pin_role_e;

  function automatic pin_role_e role_of(input int idx);
    if (idx == PIN_WAIT) return ROLE_WAIT;
    if (idx == PIN_CLK) return ROLE_CLK;
    if (idx == PIN_AS || idx == PIN_HWR || idx == PIN_RD) return ROLE_STROBE;
    return ROLE_PLAIN;
  endfunction

  function automatic logic [PORT_W-1:0] dir_reset(input logic [1:0] mode);
    return (mode == 2'd1) ? 8'h40 : 8'h00;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFFC0,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFFC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] dat_q
);
  logic [PORT_W-1:0] dir_d, dat_d;
  logic              wr_ok, dir_en, dat_en;

  assign wr_ok  = wr && !sw_stby && !hw_stby;
  assign dir_en = hw_stby || (wr_ok && addr == DIR_ADDR);
  assign dat_en = hw_stby || (wr_ok && addr == DAT_ADDR);

  always_comb begin
    if (hw_stby) begin
      dir_d = dir_reset(mode);
      dat_d = '0;
    end else begin
      dir_d = wdata;
      dat_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= dir_reset(mode);
      dat_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assert_hw_stby_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == dir_reset($past(mode)) && dat_q == '0));

  assert_sw_stby_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> (dir_q == $past(dir_q) && dat_q == $past(dat_q)));

  assert_data_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sw_stby && !hw_stby && addr == DAT_ADDR) |=> dat_q == $past(wdata));
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st_q, st_d;

  always_comb begin
    st_d[0] = din;
    for (int k = 1; k < STAGES; k++) st_d[k] = st_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign dout = st_q[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    assert_sync_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[k] == $past(st_q[k-1]));
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] dat_q,
  input  logic              wait_en,
  input  logic              sys_clk,
  input  logic              as_n,
  input  logic              hwr_n,
  input  logic              rd_n,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] out
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam pin_role_e ROLE = role_of(i);
    if (ROLE == ROLE_WAIT) begin : g_wait
      assign oe[i]  = dir_q[i] && !wait_en;
      assign out[i] = dat_q[i];
    end else if (ROLE == ROLE_CLK) begin : g_clk
      assign oe[i]  = dir_q[i];
      assign out[i] = dir_q[i] ? sys_clk : dat_q[i];
    end else if (ROLE == ROLE_STROBE) begin : g_strobe
      assign oe[i]  = 1'b1;
      if (i == PIN_AS) begin : g_as
        assign out[i] = as_n;
      end else if (i == PIN_HWR) begin : g_hwr
        assign out[i] = hwr_n;
      end else begin : g_rd
        assign out[i] = rd_n;
      end
    end else begin : g_plain
      assign oe[i]  = dir_q[i];
      assign out[i] = dat_q[i];
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFFC0,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFFC1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              wait_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sys_clk,
  input  logic              as_n,
  input  logic              hwr_n,
  input  logic              rd_n,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_oe,
  output logic [7:0]        pad_out,
  output logic              wait_out,
  output logic              subclk_out
);
  logic [PORT_W-1:0] dir_q, dat_q, pad_sync;

  gpio_port_regs #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .dir_q(dir_q), .dat_q(dat_q)
  );

  gpio_pad_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pad_sync)
  );

  gpio_pin_mux u_mux (
    .dir_q(dir_q), .dat_q(dat_q), .wait_en(wait_en), .sys_clk(sys_clk),
    .as_n(as_n), .hwr_n(hwr_n), .rd_n(rd_n), .oe(pad_oe), .out(pad_out)
  );

  always_comb begin
    if (reg_addr == DIR_ADDR)      reg_rdata = '1;
    else if (reg_addr == DAT_ADDR) reg_rdata = (dir_q & dat_q) | (~dir_q & pad_sync);
    else                           reg_rdata = '0;
  end

  assign wait_out   = pad_sync[PIN_WAIT];
  assign subclk_out = pad_sync[PIN_CLK];

  assert_strobe_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe[PIN_AS] && pad_oe[PIN_HWR] && pad_oe[PIN_RD] &&
     pad_out[PIN_AS] == as_n && pad_out[PIN_HWR] == hwr_n && pad_out[PIN_RD] == rd_n));

  assert_wait_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_en |-> !pad_oe[PIN_WAIT]);

  assert_clk_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[PIN_CLK] |-> (pad_oe[PIN_CLK] && pad_out[PIN_CLK] == sys_clk));

  assert_plain_pin7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_en |-> (pad_oe[PIN_WAIT] == dir_q[PIN_WAIT]));
endmodule

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        hw_stby, sw_stby, wait_en;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        sys_clk, as_n, hwr_n, rd_n;
  logic [7:0]  pad_in, pad_oe, pad_out;
  logic        wait_out, subclk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .wait_en(wait_en), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_clk(sys_clk), .as_n(as_n), .hwr_n(hwr_n), .rd_n(rd_n),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .wait_out(wait_out),
    .subclk_out(subclk_out)
  );

  // {dir, data, wait_en, {as_n,hwr_n,rd_n}, sys_clk, expected oe, expected out}
  localparam int NV = 5;
  localparam logic [36:0] VEC [NV] = '{
    {8'hFF, 8'h00, 1'b0, 3'b101, 1'b1, 8'hFF, 8'h68},
    {8'hFF, 8'hFF, 1'b1, 3'b010, 1'b0, 8'h7F, 8'h97},
    {8'h00, 8'hAA, 1'b0, 3'b111, 1'b1, 8'h38, 8'hBA},
    {8'h05, 8'h55, 1'b0, 3'b000, 1'b0, 8'h3D, 8'h45},
    {8'hC2, 8'h3C, 1'b1, 3'b110, 1'b1, 8'h7A, 8'h74}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd1; hw_stby = 0; sw_stby = 0; wait_en = 0;
    reg_addr = 16'hFFC1; reg_wr = 0; reg_wdata = 0;
    sys_clk = 0; as_n = 1; hwr_n = 1; rd_n = 1; pad_in = 8'h00;
    do_reset(2'd1);

    // R2: mode 1 reset, pin 6 enabled, strobes enabled
    chk("R2 oe mode1", pad_oe, 8'h78);
    chk("R2 out", pad_out, 8'h38);
    reg_addr = 16'hFFC1; #1;
    chk("R2 data read", reg_rdata, 8'h00);

    // Vector walk: R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr_reg(16'hFFC0, VEC[v][36:29]);
      wr_reg(16'hFFC1, VEC[v][28:21]);
      wait_en = VEC[v][20];
      {as_n, hwr_n, rd_n} = VEC[v][19:17];
      sys_clk = VEC[v][16];
      @(negedge clk);
      chk($sformatf("R5/R6/R7/R8 vec%0d oe", v), pad_oe, VEC[v][15:8]);
      chk($sformatf("R5/R6/R7/R8 vec%0d out", v), pad_out, VEC[v][7:0]);
    end
    wait_en = 0; {as_n, hwr_n, rd_n} = 3'b111; sys_clk = 0;

    // R9 R10: read mux and two-edge latency
    wr_reg(16'hFFC0, 8'h0F);
    wr_reg(16'hFFC1, 8'hA5);
    reg_addr = 16'hFFC1;
    pad_in = 8'hFF;
    @(negedge clk);
    chk("R9 one edge", reg_rdata, 8'h05);
    chk("R10 one edge", {6'd0, wait_out, subclk_out}, 8'h00);
    @(negedge clk);
    chk("R9 two edges", reg_rdata, 8'hF5);
    chk("R10 two edges", {6'd0, wait_out, subclk_out}, 8'h03);

    // R4: software standby freezes registers
    wr_reg(16'hFFC0, 8'h06);
    wr_reg(16'hFFC1, 8'h00);
    sw_stby = 1'b1;
    wr_reg(16'hFFC0, 8'hFF);
    wr_reg(16'hFFC1, 8'hFF);
    @(negedge clk);
    chk("R4 dir held", pad_oe, 8'h3E);
    reg_addr = 16'hFFC1; #1;
    chk("R4 data held", reg_rdata, 8'hF9);
    sw_stby = 1'b0;
    @(negedge clk);
    chk("R4 after exit", pad_oe, 8'h3E);

    // R3: hardware standby in mode 1
    wr_reg(16'hFFC0, 8'hFF);
    wr_reg(16'hFFC1, 8'hFF);
    hw_stby = 1'b1;
    @(negedge clk);
    hw_stby = 1'b0;
    @(negedge clk);
    chk("R3 dir reload", pad_oe, 8'h78);
    reg_addr = 16'hFFC1; #1;
    chk("R3 data reload", reg_rdata, 8'hBF);

    // R2: mode 2 reset
    do_reset(2'd2);
    chk("R2 oe mode2", pad_oe, 8'h38);

    // R1: unmatched address has no effect, reads zero
    wr_reg(16'hFFC2, 8'hFF);
    @(negedge clk);
    chk("R1 stray write", pad_oe, 8'h38);
    reg_addr = 16'hFFC2; #1;
    chk("R1 stray read", reg_rdata, 8'h00);
    wr_reg(16'hFFC0, 8'h01);
    chk("R1 matched write", pad_oe, 8'h39);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule